// File: doc/BRIEF.md
# Multi-Byte In-Frame Response Transmitter

This block sequences the sending of a multi-byte in-frame response, without a check byte, on a byte-oriented serial data link. The host arms it with a request bit before the current frame's end-of-data symbol arrives. It loads the first response byte into a one-byte holding register. When the link reports a valid end-of-data, the block drives a normalization symbol and then shifts the byte out most significant bit first. Each time the holding register is moved into the shift register, the block raises a one-cycle empty request, and the host answers with the next byte. A host end-of-data command marks the byte most recently written as the final one. That byte is followed by an end-of-data symbol.

The bus side is abstracted to symbols. The block presents one symbol at a time on `tx_sym`/`tx_bit`. The link consumes it on a cycle where `bus_strobe` is high and returns the sampled bus level on `bus_echo` in that same cycle. When a driven 1 reads back as 0, arbitration is lost and the block gives up without retrying. If that happens on the last bit of a byte, it first drives two extra 1 bits so that receivers see a byte-boundary fault. A bus error, a host underrun or a completed end-of-data all end the attempt. Each cause produces its own one-cycle pulse, and the request bit clears.

Top module: `ifr_tx`

## Requirements
- R1: A request set before a valid end-of-data (while `idle`) raises `req_q` at once. No symbol is driven until `frame_eod`. The first symbol is then normalization (`tx_sym`=1), followed by the first byte as data bits (`tx_sym`=2, value on `tx_bit`), most significant bit first.
- R2: A request set after `frame_eod` and before the next `frame_start` is ignored. `req_q` stays 0, `idle` stays 1 and `tx_sym` stays 0 (none).
- R3: Every move of the holding register into the shift register gives a one-cycle `tdre` pulse in the next cycle. A completed or underrun response therefore yields one pulse per byte sent.
- R4: After `host_eod`, the byte last written is the final byte. The end-of-data symbol (`tx_sym`=3) follows its last bit. One cycle after the end-of-data symbol is consumed, `done_ok` pulses.
- R5: No check byte is added. A response of n bytes is exactly 8n+2 symbols: one normalization, the data bits and one end-of-data.
- R6: If arbitration is lost on any bit but the last of a byte, the block stops at once. It pulses `done_arb`, retransmits nothing and drives no further symbol.
- R7: If arbitration is lost on the last bit of a byte, two data bits of value 1 follow. `done_arb` pulses after them.
- R8: A bus error during an attempt ends it. `done_err` pulses in the next cycle and no further symbol is driven.
- R9: If the shift register finishes a byte while the holding register is empty and no end-of-data command is pending, the attempt ends with `done_urun`. No end-of-data symbol is sent.
- R10: Each termination pulses exactly one cause for one cycle, and in that cycle `req_q` is 0 and `idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | 1 | Host sets the response request |
| frame_start | input | 1 | A new frame begins on the link |
| frame_eod | input | 1 | Valid end-of-data received with good check byte |
| host_wr | input | 1 | Host writes the holding register |
| host_data | input | DW | Byte written by the host |
| host_eod | input | 1 | Host end-of-data command |
| bus_strobe | input | 1 | Link consumes the presented symbol this cycle |
| bus_echo | input | 1 | Bus level sampled for the consumed bit |
| bus_err | input | 1 | Link reports a bus error |
| req_q | output | 1 | Request bit state |
| tdre | output | 1 | Holding register empty request pulse |
| tx_sym | output | 2 | Symbol kind: 0 none, 1 normalization, 2 data bit, 3 end-of-data |
| tx_bit | output | 1 | Data bit value when `tx_sym`=2 |
| idle | output | 1 | No request pending or in progress |
| done_ok | output | 1 | Pulse: response completed |
| done_arb | output | 1 | Pulse: arbitration lost |
| done_err | output | 1 | Pulse: bus error |
| done_urun | output | 1 | Pulse: host underrun |

## Verification
Each symbol changes one edge after the strobe that consumes its predecessor. `tdre` and every cause pulse come from a register and appear in the cycle after the edge that caused them. The bench drives on the falling edge and samples in the same half-cycle. It logs the symbol, answers the echo and refills the holding register the moment `tdre` is seen, so every result is read exactly one edge after its cause. Sweeps cover response lengths, each arbitration-loss bit position across two bytes, error positions and underrun lengths, with expected symbol streams built arithmetically in the bench.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_NORM, ST_SHIFT, ST_PAD, ST_EOD
  } ifr_st_t;

  typedef enum logic [2:0] {
    END_NONE, END_OK, END_ARB, END_ERR, END_URUN
  } ifr_end_t;

  localparam logic [1:0] SYM_NONE = 2'd0;
  localparam logic [1:0] SYM_NORM = 2'd1;
  localparam logic [1:0] SYM_BIT  = 2'd2;
  localparam logic [1:0] SYM_EOD  = 2'd3;

  // a recessive 1 overwritten by a dominant 0 on the wire
  function automatic logic arb_lost(input logic driven, input logic seen);
    return driven & ~seen;
  endfunction

  // request may be armed only while the frame's end-of-data is still ahead
  function automatic logic arm_allowed(input logic req, input logic eod_seen,
                                       input logic eod_now);
    return req & ~eod_seen & ~eod_now;
  endfunction
endpackage

// File: rtl/ifr_hold.sv
module ifr_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          eod_set,
  input  logic          take,
  input  logic          flush,
  output logic          full,
  output logic [DW-1:0] dout,
  output logic          eod_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      dout     <= '0;
      eod_pend <= 1'b0;
    end else if (flush) begin
      full     <= 1'b0;
      eod_pend <= 1'b0;
    end else begin
      if (wr) dout <= wdata;
      full     <= wr | (full & ~take);
      eod_pend <= eod_pend | eod_set;
    end
  end

  AST_TAKE_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full); // R3
endmodule

// File: rtl/ifr_shift.sv
module ifr_shift import ifr_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  input  logic          adv,
  input  logic          echo,
  output logic          drv_bit,
  output logic          last_bit,
  output logic          lost
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= ldata;
      cnt <= '0;
    end else if (adv) begin
      sr  <= {sr[DW-2:0], 1'b0};
      cnt <= cnt + 1'b1;
    end
  end

  assign drv_bit  = sr[DW-1];
  assign last_bit = (cnt == CW'(DW-1));
  assign lost     = arb_lost(drv_bit, echo);

  AST_LOAD_NOT_MIDBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && adv) |-> last_bit); // R3
endmodule

// File: rtl/ifr_ctrl.sv
module ifr_ctrl import ifr_pkg::*; #(
  parameter int PAD_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_set,
  input  logic       frame_start,
  input  logic       frame_eod,
  input  logic       bus_err,
  input  logic       bus_strobe,
  input  logic       hold_full,
  input  logic       hold_eod,
  input  logic       sh_last,
  input  logic       sh_lost,
  input  logic       sh_bit,
  output logic       take,
  output logic       adv,
  output logic       flush,
  output logic       req_q,
  output logic       tdre,
  output logic [1:0] tx_sym,
  output logic       tx_bit,
  output logic       idle,
  output logic       done_ok,
  output logic       done_arb,
  output logic       done_err,
  output logic       done_urun
);
  localparam int PW = $clog2(PAD_N + 1);

  ifr_st_t  st, nxt;
  ifr_end_t end_c;
  logic [PW-1:0] pad_cnt, pad_nxt;
  logic eod_seen;
  logic arm_ok;

  assign arm_ok = arm_allowed(req_set, eod_seen, frame_eod);

  always_comb begin
    nxt     = st;
    pad_nxt = pad_cnt;
    take    = 1'b0;
    adv     = 1'b0;
    end_c   = END_NONE;
    unique case (st)
      ST_IDLE: if (arm_ok) nxt = ST_ARMED;
      ST_ARMED: begin
        if (bus_err) end_c = END_ERR;
        else if (frame_eod) begin
          if (hold_full) begin
            take = 1'b1;
            nxt  = ST_NORM;
          end else end_c = END_URUN;
        end
      end
      ST_NORM: begin
        if (bus_err) end_c = END_ERR;
        else if (bus_strobe) nxt = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (bus_err) end_c = END_ERR;
        else if (bus_strobe) begin
          adv = 1'b1;
          if (sh_lost) begin
            if (sh_last) begin
              nxt     = ST_PAD;
              pad_nxt = '0;
            end else end_c = END_ARB;
          end else if (sh_last) begin
            if (hold_full) take = 1'b1;
            else if (hold_eod) nxt = ST_EOD;
            else end_c = END_URUN;
          end
        end
      end
      ST_PAD: begin
        if (bus_err) end_c = END_ERR;
        else if (bus_strobe) begin
          if (pad_cnt == PW'(PAD_N - 1)) end_c = END_ARB;
          else pad_nxt = pad_cnt + 1'b1;
        end
      end
      ST_EOD: begin
        if (bus_err) end_c = END_ERR;
        else if (bus_strobe) end_c = END_OK;
      end
      default: nxt = ST_IDLE;
    endcase
    flush = (end_c != END_NONE);
    if (flush) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pad_cnt   <= '0;
      eod_seen  <= 1'b0;
      tdre      <= 1'b0;
      done_ok   <= 1'b0;
      done_arb  <= 1'b0;
      done_err  <= 1'b0;
      done_urun <= 1'b0;
    end else begin
      st        <= nxt;
      pad_cnt   <= pad_nxt;
      tdre      <= take;
      done_ok   <= (end_c == END_OK);
      done_arb  <= (end_c == END_ARB);
      done_err  <= (end_c == END_ERR);
      done_urun <= (end_c == END_URUN);
      if (frame_start) eod_seen <= 1'b0;
      else if (frame_eod) eod_seen <= 1'b1;
    end
  end

  always_comb begin
    tx_bit = 1'b0;
    unique case (st)
      ST_NORM:  tx_sym = SYM_NORM;
      ST_SHIFT: begin tx_sym = SYM_BIT; tx_bit = sh_bit; end
      ST_PAD:   begin tx_sym = SYM_BIT; tx_bit = 1'b1;   end
      ST_EOD:   tx_sym = SYM_EOD;
      default:  tx_sym = SYM_NONE;
    endcase
  end

  assign idle  = (st == ST_IDLE);
  assign req_q = ~idle;

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, done_arb, done_err, done_urun})); // R10
  AST_END_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_arb || done_err || done_urun) |-> (idle && !req_q)); // R10
  AST_LATE_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && eod_seen && !frame_start && req_set) |=> idle); // R2
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !idle) |=> (done_err && tx_sym == SYM_NONE)); // R8
  AST_PAD_AFTER_LAST_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sym == SYM_BIT && bus_strobe && !bus_err && sh_lost && sh_last && st == ST_SHIFT)
    |=> (tx_sym == SYM_BIT && tx_bit)); // R7
  AST_NO_SYM_WHILE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED) |-> (tx_sym == SYM_NONE)); // R1
endmodule

// File: rtl/ifr_tx.sv
module ifr_tx import ifr_pkg::*; #(
  parameter int DW    = 8,
  parameter int PAD_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_set,
  input  logic          frame_start,
  input  logic          frame_eod,
  input  logic          host_wr,
  input  logic [DW-1:0] host_data,
  input  logic          host_eod,
  input  logic          bus_strobe,
  input  logic          bus_echo,
  input  logic          bus_err,
  output logic          req_q,
  output logic          tdre,
  output logic [1:0]    tx_sym,
  output logic          tx_bit,
  output logic          idle,
  output logic          done_ok,
  output logic          done_arb,
  output logic          done_err,
  output logic          done_urun
);
  logic          take, adv, flush;
  logic          hold_full, hold_eod;
  logic [DW-1:0] hold_data;
  logic          sh_bit, sh_last, sh_lost;

  ifr_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_data),
    .eod_set(host_eod), .take(take), .flush(flush),
    .full(hold_full), .dout(hold_data), .eod_pend(hold_eod)
  );

  ifr_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(take), .ldata(hold_data),
    .adv(adv), .echo(bus_echo),
    .drv_bit(sh_bit), .last_bit(sh_last), .lost(sh_lost)
  );

  ifr_ctrl #(.PAD_N(PAD_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .frame_start(frame_start),
    .frame_eod(frame_eod), .bus_err(bus_err), .bus_strobe(bus_strobe),
    .hold_full(hold_full), .hold_eod(hold_eod),
    .sh_last(sh_last), .sh_lost(sh_lost), .sh_bit(sh_bit),
    .take(take), .adv(adv), .flush(flush),
    .req_q(req_q), .tdre(tdre), .tx_sym(tx_sym), .tx_bit(tx_bit), .idle(idle),
    .done_ok(done_ok), .done_arb(done_arb), .done_err(done_err),
    .done_urun(done_urun)
  );

  AST_EOD_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sym == SYM_EOD) |-> hold_eod); // R4
endmodule

// File: tb/ifr_tx_tb.sv
module ifr_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_set = 0, frame_start = 0, frame_eod = 0;
  logic host_wr = 0, host_eod = 0;
  logic [7:0] host_data = '0;
  logic bus_strobe = 0, bus_echo = 0, bus_err = 0;
  logic req_q, tdre, tx_bit, idle, done_ok, done_arb, done_err, done_urun;
  logic [1:0] tx_sym;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ifr_tx u_dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .frame_start(frame_start),
    .frame_eod(frame_eod), .host_wr(host_wr), .host_data(host_data),
    .host_eod(host_eod), .bus_strobe(bus_strobe), .bus_echo(bus_echo),
    .bus_err(bus_err), .req_q(req_q), .tdre(tdre), .tx_sym(tx_sym),
    .tx_bit(tx_bit), .idle(idle), .done_ok(done_ok), .done_arb(done_arb),
    .done_err(done_err), .done_urun(done_urun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int n, input int i, input bit ones);
    return ones ? 8'hFF : 8'((n * 37 + i * 91 + 5) & 255);
  endfunction

  // cause codes: 0 ok, 1 arb, 2 err, 3 underrun, 4 none
  task automatic run_frame(input int n, input bit eod, input int loss_k,
                           input int err_j, input bit ones);
    int exp_k[64]; int exp_b[64]; int obs_k[64]; int obs_b[64];
    int len, cnt, bits, wr, tdres, cause, exp_cause, mism;
    string tag;
    exp_k[0] = 1; exp_b[0] = 0; len = 1;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        exp_k[len] = 2; exp_b[len] = int'(pat(n, i, ones) >> b) & 1; len++;
      end
    if (eod) begin exp_k[len] = 3; exp_b[len] = 0; len++; end
    if (loss_k >= 0) begin
      len = loss_k + 2; exp_cause = 1;
      if (loss_k % 8 == 7) begin
        exp_k[len] = 2; exp_b[len] = 1; exp_k[len+1] = 2; exp_b[len+1] = 1; len += 2;
        tag = "R7";
      end else tag = "R6";
    end else if (err_j >= 0) begin
      len = err_j + 1; exp_cause = 2; tag = "R8";
    end else if (eod) begin exp_cause = 0; tag = "R1 R4 R5"; end
    else begin exp_cause = 3; tag = "R9"; end

    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0; req_set = 1; host_wr = 1;
    host_data = pat(n, 0, ones); host_eod = (n == 1) && eod;
    @(negedge clk); req_set = 0; host_wr = 0; host_eod = 0;
    chk(req_q === 1'b1 && tx_sym === 2'd0, "R1 armed", int'(req_q), 1);
    repeat (3) @(negedge clk);
    chk(tx_sym === 2'd0, "R1 waits for eod", int'(tx_sym), 0);
    frame_eod = 1;
    cnt = 0; bits = 0; wr = 1; tdres = 0; cause = 4;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      frame_eod = 0;
      if (done_ok || done_arb || done_err || done_urun) begin
        cause = done_ok ? 0 : done_arb ? 1 : done_err ? 2 : 3;
        chk(idle === 1'b1 && req_q === 1'b0 &&
            (int'(done_ok) + int'(done_arb) + int'(done_err) + int'(done_urun)) == 1,
            "R10 end state", int'(req_q), 0);
        break;
      end
      if (tdre) tdres++;
      bus_err = 0; bus_echo = tx_bit;
      if (tx_sym != 2'd0) begin
        if (cnt < 64) begin obs_k[cnt] = int'(tx_sym); obs_b[cnt] = int'(tx_bit); end
        if (tx_sym == 2'd2) begin
          if (bits == loss_k) bus_echo = 1'b0;
          bits++;
        end
        if (cnt == err_j) bus_err = 1;
        cnt++;
      end
      host_wr = 0; host_eod = 0;
      if (tdre && wr < n) begin
        host_data = pat(n, wr, ones); host_wr = 1; wr++;
        if (wr == n && eod) host_eod = 1;
      end
      bus_strobe = 1;
    end
    bus_strobe = 0; bus_err = 0; bus_echo = 0; host_wr = 0; host_eod = 0;
    chk(cause == exp_cause, {tag, " cause"}, cause, exp_cause);
    chk(cnt == len, {tag, " symbol count"}, cnt, len);
    mism = 0;
    for (int i = 0; i < len && i < cnt && i < 64; i++)
      if (obs_k[i] != exp_k[i] || (obs_k[i] == 2 && obs_b[i] != exp_b[i])) mism++;
    chk(mism == 0, {tag, " symbol stream"}, mism, 0);
    if (exp_cause == 0 || exp_cause == 3)
      chk(tdres == n, "R3 tdre count", tdres, n);
    @(negedge clk);
    chk(tx_sym === 2'd0 && idle === 1'b1, {tag, " quiet after end"}, int'(tx_sym), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(idle === 1'b1 && req_q === 1'b0 && tx_sym === 2'd0 && tdre === 1'b0,
        "R10 reset state", int'(req_q), 0);
    rst_n = 1;
    @(negedge clk);
    for (int n = 1; n <= 4; n++) run_frame(n, 1'b1, -1, -1, 1'b0);   // R4 R5
    for (int n = 1; n <= 3; n++) run_frame(n, 1'b0, -1, -1, 1'b0);   // R9
    for (int k = 0; k < 16; k++) run_frame(2, 1'b1, k, -1, 1'b1);    // R6 R7
    for (int j = 0; j < 6; j++) run_frame(2, 1'b1, -1, j, 1'b0);     // R8
    // R2: request after the frame's end-of-data is ignored
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0; frame_eod = 1;
    @(negedge clk); frame_eod = 0; req_set = 1; host_wr = 1; host_data = 8'hA5;
    @(negedge clk); req_set = 0; host_wr = 0;
    chk(req_q === 1'b0 && idle === 1'b1, "R2 late request", int'(req_q), 0);
    begin
      int busy = 0;
      bus_strobe = 1;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (tx_sym !== 2'd0 || req_q !== 1'b0) busy++;
      end
      bus_strobe = 0;
      chk(busy == 0, "R2 no symbols", busy, 0);
    end
    run_frame(3, 1'b1, -1, -1, 1'b0);  // R1 arming works again after new frame
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule